// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing controller of a byte-wide serial memory that sits on a shared two-wire bus. It runs in a fast system clock domain. It oversamples the bus clock and data lines and recognises start conditions, stop conditions and bus clock edges. It acknowledges only a device select byte whose two pin bits match its strapping inputs. It then collects a two-byte word address and serves byte writes, page writes, current-address reads, random reads and sequential reads. It never drives the data line high. It only asserts an enable that pulls the line low.

Written bytes are collected in a one-page buffer and go into the storage array only when the stop condition arrives. After such a commit the block runs a busy period whose length is set by a parameter. While that period runs it refuses its select byte, so a master can poll for completion. A write-protect input, sampled at the stop, discards the buffered page. A standby flag shows when the block is idle with no internal work pending. The word address is always 16 bits and pages are 128 bytes. The physical array is a parameterised power-of-two size, and the word address folds onto it.

Top module: `ee2w_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. A start begins a fresh command from any state and discards any partly received transfer. A rising data line while the clock is high is a stop, and a stop returns the block to idle.
- R2: The select byte is sent most significant bit first. Bits 7..3 must be 10100, bits 2..1 must equal the pin inputs (bit 2 = pin 1), and bit 0 is the direction (1 = read). Any other select byte gets no acknowledge.
- R3: Each byte the slave accepts is acknowledged by a low data line for the whole ninth clock. The slave changes its drive only while the clock is low.
- R4: After a write select, the next two bytes set the 16-bit word address, high byte first.
- R5: Write data bytes land at successive addresses. Only the low 7 bits step, and they wrap within the current 128-byte page. Nothing reaches the array before the stop.
- R6: If the write-protect input is high at the stop, no byte is committed and no busy period starts. The data bytes are still acknowledged.
- R7: After a committed write the slave leaves its select byte unacknowledged until the commit and BUSY_CYC system clocks have elapsed. After that it acknowledges again.
- R8: Reads return the byte at the current pointer and then step the full 16-bit pointer, rolling from 0xFFFF to 0x0000. A read select with no address phase starts at the pointer left by the last access. A read ends when the master does not acknowledge.
- R9: A write select with an address, then a repeated start and a read select, returns data from that address.
- R10: The standby flag is high after reset and after a stop once any busy period is over. It is low during a transfer and during the busy period.
- R11: Nine bus clocks with the data line high followed by a start recover the bus. A write byte received before that start is never committed.
- R12: The array holds 2^MEM_AW bytes. The low MEM_AW bits of the word address select the byte, so addresses that differ only above bit MEM_AW-1 share a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sel_pins_i | input | 2 | Strapped device select pins, compared with select byte bits 2..1 |
| wp_i | input | 1 | Write protect; high blocks commits |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| standby_o | output | 1 | High when idle with no internal operation pending |

## Verification
The checks on the slave's own drive assume that sda_i is the wired-AND of the master's line and the slave's enable. They also assume that the master moves the data line only while the clock is low, except when it makes a start or a stop. The bench models the line exactly that way. Its bus master changes data a quarter bus period after each clock fall and holds every bus phase for several system clocks, so the synchroniser always sees each level. The busy and write-protect checks assume wp_i stays steady around a stop, and the bench changes it only while the bus is idle.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  localparam int WORD_AW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } ee_state_t;

  // select byte check: 1010 0 pin1 pin0 then direction bit
  function automatic logic sel_match(input logic [7:0] b, input logic [1:0] pins);
    return (b[7:3] == 5'b10100) && (b[2:1] == pins);
  endfunction

  // step the address inside its page; pmask has ones on the in-page bits
  function automatic logic [WORD_AW-1:0] page_step(input logic [WORD_AW-1:0] a,
                                                   input logic [WORD_AW-1:0] pmask);
    return (a & ~pmask) | ((a + 1'b1) & pmask);
  endfunction

endpackage

// File: rtl/ee2w_bus_det.sv
module ee2w_bus_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_p  <= scl_sh[SYNC-1];
      sda_p  <= sda_sh[SYNC-1];
    end
  end

  assign scl_s    = scl_sh[SYNC-1];
  assign sda_s    = sda_sh[SYNC-1];
  assign start_ev = scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;

endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
  parameter int PAGE_AW = 7,
  parameter int BASE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic [BASE_W-1:0]         base_i,
  input  logic                      wr_i,
  input  logic [PAGE_AW-1:0]        idx_i,
  input  logic [7:0]                data_i,
  input  logic                      go_i,
  output logic                      run_o,
  output logic                      we_o,
  output logic [BASE_W+PAGE_AW-1:0] waddr_o,
  output logic [7:0]                wdata_o
);

  localparam int PAGE_N = 1 << PAGE_AW;

  logic [7:0]         pbuf [PAGE_N];
  logic [PAGE_N-1:0]  vld;
  logic [BASE_W-1:0]  base_q;
  logic [PAGE_AW-1:0] cidx;
  logic               run;

  always_ff @(posedge clk) begin
    if (wr_i) pbuf[idx_i] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      base_q <= '0;
      cidx   <= '0;
      run    <= 1'b0;
    end else begin
      if (clr_i) begin
        vld    <= '0;
        base_q <= base_i;
      end else if (wr_i) begin
        vld[idx_i] <= 1'b1;
      end
      if (go_i) begin
        run  <= 1'b1;
        cidx <= '0;
      end else if (run) begin
        cidx <= cidx + 1'b1;
        if (cidx == '1) run <= 1'b0;
      end
    end
  end

  assign run_o   = run;
  assign we_o    = run && vld[cidx];
  assign waddr_o = {base_q, cidx};
  assign wdata_o = pbuf[cidx];

  // R5
  no_fill_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i || clr_i) |-> !run);

endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int MEM_AW = 11,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0]        cells [DEPTH];
  logic [MEM_AW-1:0] widx, ridx;

  assign widx    = MEM_AW'(waddr_i);
  assign ridx    = MEM_AW'(raddr_i);
  assign rdata_o = cells[ridx];

  always_ff @(posedge clk) begin
    if (we_i) cells[widx] <= wdata_i;
  end

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int PAGE_AW  = 7,
  parameter int MEM_AW   = 11,
  parameter int BUSY_CYC = 4000,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_pins_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       standby_o
);

  localparam int BASE_W = WORD_AW - PAGE_AW;
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);
  localparam logic [WORD_AW-1:0] PMASK = WORD_AW'((1 << PAGE_AW) - 1);

  // bus events
  logic scl_s, sda_s, start_ev, stop_ev, scl_rise, scl_fall;

  ee2w_bus_det #(.SYNC(SYNC)) u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  ee_state_t          st, nxt_q, nxt_d;
  logic [3:0]         bit_cnt;
  logic               in_ack, mack, pend, oe_q;
  logic [7:0]         shreg, txsh, addr_hi;
  logic [WORD_AW-1:0] addr, full_addr;
  logic [BUSY_W-1:0]  busy_cnt;
  logic               ack_dec, rx_state, byte_ev, ack_end, sel_hit, busy;
  logic               commit_go, pb_clr, pb_wr, pb_run, mem_we;
  logic [WORD_AW-1:0] mem_waddr;
  logic [7:0]         mem_wdata, mem_rdata;

  assign rx_state  = (st == ST_DEVSEL) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDATA);
  assign byte_ev   = rx_state && scl_fall && !in_ack && (bit_cnt == 4'd8);
  assign ack_end   = rx_state && scl_fall && in_ack;
  assign busy      = (busy_cnt != '0) || pb_run;
  assign sel_hit   = sel_match(shreg, sel_pins_i) && !busy;
  assign full_addr = {addr_hi, shreg};
  assign pb_clr    = byte_ev && (st == ST_ALO);
  assign pb_wr     = byte_ev && (st == ST_WDATA);
  assign commit_go = stop_ev && pend && !wp_i;

  always_comb begin
    ack_dec = 1'b1;
    nxt_d   = st;
    case (st)
      ST_DEVSEL: begin
        ack_dec = sel_hit;
        nxt_d   = shreg[0] ? ST_RDATA : ST_AHI;
      end
      ST_AHI:   nxt_d = ST_ALO;
      ST_ALO:   nxt_d = ST_WDATA;
      ST_WDATA: nxt_d = ST_WDATA;
      default:  ack_dec = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      mack    <= 1'b0;
      pend    <= 1'b0;
      oe_q    <= 1'b0;
      shreg   <= '0;
      txsh    <= '0;
      addr_hi <= '0;
      addr    <= '0;
    end else if (start_ev) begin
      st      <= ST_DEVSEL;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      pend    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      pend    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_SKIP: ;
        ST_RDATA: begin
          if (scl_rise) begin
            if (in_ack) mack <= !sda_s;
            else if (bit_cnt < 4'd8) bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              if (mack) begin
                txsh    <= mem_rdata;
                oe_q    <= !mem_rdata[7];
                bit_cnt <= '0;
              end else begin
                st   <= ST_SKIP;
                oe_q <= 1'b0;
              end
            end else if (bit_cnt == 4'd8) begin
              oe_q   <= 1'b0;
              in_ack <= 1'b1;
              addr   <= addr + 1'b1;
            end else if (bit_cnt != '0) begin
              oe_q <= !txsh[6];
              txsh <= txsh << 1;
            end
          end
        end
        default: begin
          if (scl_rise && !in_ack && (bit_cnt < 4'd8)) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_ev) begin
            if (ack_dec) begin
              in_ack <= 1'b1;
              oe_q   <= 1'b1;
              nxt_q  <= nxt_d;
            end else begin
              st <= ST_SKIP;
            end
            case (st)
              ST_AHI:   addr_hi <= shreg;
              ST_ALO:   addr    <= full_addr;
              ST_WDATA: begin
                addr <= page_step(addr, PMASK);
                pend <= 1'b1;
              end
              default: ;
            endcase
          end else if (ack_end) begin
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            st      <= nxt_q;
            if (nxt_q == ST_RDATA) begin
              txsh <= mem_rdata;
              oe_q <= !mem_rdata[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (commit_go) busy_cnt <= BUSY_W'(BUSY_CYC);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  ee2w_page_buf #(.PAGE_AW(PAGE_AW), .BASE_W(BASE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr_i(pb_clr), .base_i(full_addr[WORD_AW-1:PAGE_AW]),
    .wr_i(pb_wr), .idx_i(addr[PAGE_AW-1:0]), .data_i(shreg), .go_i(commit_go),
    .run_o(pb_run), .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  ee2w_array #(.MEM_AW(MEM_AW), .ADDR_W(WORD_AW)) u_arr (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(addr), .rdata_o(mem_rdata)
  );

  assign sda_oe_o  = oe_q;
  assign standby_o = (st == ST_IDLE) && !busy;

  // R3
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(scl_s));

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && (st == ST_DEVSEL) && busy) |=> !oe_q);

  // R6
  wp_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_ev) && !$past(wp_i)));

  // R5
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && (st == ST_WDATA)) |=> (addr[WORD_AW-1:PAGE_AW] == $past(addr[WORD_AW-1:PAGE_AW])));

  // R8
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RDATA) && ($past(addr) == '1) && (addr != '1)) |-> (addr == '0));

  // R10
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !oe_q);

endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int BUSY       = 300;
  localparam int MAW        = 11;
  localparam logic [1:0] PINS = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [1:0] pins = PINS;
  logic sda_oe, standby, sda_line;
  int checks = 0, fails = 0, cyc = 0;

  logic [7:0] mdl  [0:(1<<MAW)-1];
  logic [7:0] wbuf [0:7];

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee2w_slave #(.PAGE_AW(7), .MEM_AW(MAW), .BUSY_CYC(BUSY), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sel_pins_i(pins),
    .wp_i(wp), .sda_oe_o(sda_oe), .standby_o(standby)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int midx(input logic [15:0] a);
    return int'(a[MAW-1:0]);
  endfunction

  function automatic logic [15:0] in_page_next(input logic [15:0] a);
    return {a[15:7], 7'(a[6:0] + 7'd1)};
  endfunction

  function automatic logic [7:0] sel_byte(input logic [1:0] p, input logic rd);
    return {5'b10100, p, rd};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); b = sda_line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic start_c();
    sda_m = 1'b1; qwait(); scl = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; qwait(); scl = 1'b1; qwait(); sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic more);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(!more);
  endtask

  // page write of n bytes from wbuf; model follows unless protected
  task automatic wr_txn(input logic [15:0] a, input int n, input string tag);
    logic ack;
    logic [15:0] p;
    start_c();
    send_byte(sel_byte(PINS, 1'b0), ack); chk(ack, {tag, " R2 select ack"}, ack, 1);
    send_byte(a[15:8], ack);              chk(ack, {tag, " R4 addr hi ack"}, ack, 1);
    send_byte(a[7:0], ack);               chk(ack, {tag, " R4 addr lo ack"}, ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);            chk(ack, {tag, " R3 data ack"}, ack, 1);
      if (!wp) mdl[midx(p)] = wbuf[k];
      p = in_page_next(p);
    end
    stop_c();
  endtask

  // random read of n bytes starting at a, checked against the model
  task automatic rd_rand(input logic [15:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    logic [15:0] p;
    start_c();
    send_byte(sel_byte(PINS, 1'b0), ack); chk(ack, {tag, " R9 select ack"}, ack, 1);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    start_c();
    send_byte(sel_byte(PINS, 1'b1), ack); chk(ack, {tag, " R9 read select ack"}, ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      chk(d === mdl[midx(p)], {tag, " R8 read data"}, d, mdl[midx(p)]);
      p = p + 16'd1;
    end
    stop_c();
  endtask

  task automatic poll(output logic ack);
    start_c();
    send_byte(sel_byte(PINS, 1'b0), ack);
    stop_c();
  endtask

  task automatic settle();
    logic ack;
    repeat (BUSY + 200) @(negedge clk);
    poll(ack);
    chk(ack, "R7 select acked after busy", ack, 1);
  endtask

  initial begin
    logic ack, x;
    logic [7:0] d;
    logic [15:0] ra;
    int n;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(sda_oe == 1'b0, "R10 reset oe", sda_oe, 0);
    chk(standby == 1'b1, "R10 reset standby", standby, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // byte write then acknowledge polling
    wbuf[0] = 8'h5A;
    wr_txn(16'h0123, 1, "byte write");
    chk(standby == 1'b0, "R10 standby low while busy", standby, 0);
    poll(ack);
    chk(!ack, "R7 select refused while busy", ack, 0);
    settle();
    chk(standby == 1'b1, "R10 standby after busy", standby, 1);
    rd_rand(16'h0123, 1, "R9 random read");

    // R5: page wrap from 0x0A7C, six bytes
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h30 + k);
    wr_txn(16'h0A7C, 6, "R5 page wrap");
    settle();
    rd_rand(16'h0A7C, 4, "R5 page tail");
    rd_rand(16'h0A00, 1, "R5 page head");
    // R8: current-address read continues at 0x0A01
    start_c();
    send_byte(sel_byte(PINS, 1'b1), ack); chk(ack, "R8 current read select", ack, 1);
    recv_byte(d, 1'b0);
    chk(d === mdl[midx(16'h0A01)], "R8 current address data", d, mdl[midx(16'h0A01)]);
    stop_c();

    // R8: rollover from 0xFFFF to 0x0000
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    wr_txn(16'hFFFE, 2, "R8 top");
    settle();
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    wr_txn(16'h0000, 2, "R8 bottom");
    settle();
    rd_rand(16'hFFFE, 4, "R8 rollover");

    // R12: aliasing onto the smaller array
    wbuf[0] = 8'h3C;
    wr_txn(16'h0810, 1, "R12 alias write");
    settle();
    rd_rand(16'h0010, 1, "R12 alias read");

    // R6: write protect
    wp = 1'b1;
    wbuf[0] = 8'hA5;
    wr_txn(16'h0123, 1, "R6 protected");
    poll(ack);
    chk(ack, "R6 no busy after protected write", ack, 1);
    chk(standby == 1'b1, "R6 standby after protected write", standby, 1);
    wp = 1'b0;
    rd_rand(16'h0123, 1, "R6 data unchanged");

    // R2: wrong pins
    start_c();
    send_byte(sel_byte(2'b01, 1'b0), ack);
    chk(!ack, "R2 foreign select not acked", ack, 0);
    stop_c();
    start_c();
    send_byte(sel_byte(PINS, 1'b1) ^ 8'h80, ack);
    chk(!ack, "R2 wrong device code not acked", ack, 0);
    stop_c();

    // R11: recovery discards a partial write; R1 start abandons it
    wbuf[0] = 8'h77;
    wr_txn(16'h0300, 1, "R11 setup");
    settle();
    start_c();
    send_byte(sel_byte(PINS, 1'b0), ack);
    send_byte(8'h03, ack);
    send_byte(8'h00, ack);
    send_byte(8'h11, ack);
    chk(ack, "R11 interrupted byte acked", ack, 1);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    for (int k = 0; k < 9; k++) bit_in(x);
    rd_rand(16'h0300, 1, "R11 R1 recovered read");
    poll(ack);
    chk(ack, "R11 no commit after recovery", ack, 1);

    // random page writes and sequential read-back
    for (int t = 0; t < 6; t++) begin
      n  = 1 + int'($urandom % 6);
      ra = 16'($urandom);
      ra[6:0] = 7'($urandom % (128 - n));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(ra, n, "R5 random write");
      settle();
      rd_rand(ra, n, "R8 random read back");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule